// File: doc/BRIEF.md
# Text Overlay Raster Sequencer

This block turns incoming horizontal and vertical sync pulses into the raster coordinates of a text overlay. The overlay is a grid of 12 text rows by 24 columns, and each character cell is 12 dots wide and 18 scan lines tall. Each sync input has its own polarity select. Each sync is resynchronised into the dot-clock domain, and its leading edge restarts the count of dots within a line or the count of lines within a frame.

Two 6-bit start values place the grid on the screen. The horizontal start is counted in dot clocks and the vertical start in scan lines, and each has a fixed offset added. Any text row can be set to double size on its own. A double-size row shows every font dot for two clocks and every font line for two scan lines, and it takes twice the normal height before the next row begins.

On each clock the block gives the character-memory row and column, the font line and font dot within the cell, and a display-active flag. The character memory returns the code for the addressed cell combinationally on `cell_code`. If that code is the reserved blank value, the cell is suppressed.

Top module: `osd_raster_seq`

## Requirements
- R1: While `disp_active` is 1, `row_addr` lies in 0..11 and `col_addr` lies in 0..23. Row 0 is the top row and column 0 is the leftmost column.
- R2: `hsync_high`=1 makes `hsync_in` active-high and 0 makes it active-low. `vsync_high` selects the polarity of `vsync_in` in the same way. Only a transition into the active level starts a line or a frame.
- R3: Each sync passes through a two-flop synchroniser. The dot count of a line is 0 after the third rising clock edge that follows `hsync_in` entering its active level, and it then rises by one each clock.
- R4: The first displayed dot of a row has dot count 12 + `h_start`. Column c of a normal row covers dot counts 12 + `h_start` + 12c through 12 + `h_start` + 12c + 11.
- R5: After a vsync start, scan lines are numbered 1, 2, ... at each hsync start. The first displayed scan line is line number 16 + `v_start`.
- R6: In a normal row, `font_col` steps 0..11 across a cell and `font_row` steps 0..17 down the row, one step per dot and per line. The row occupies 18 lines.
- R7: When bit r of `row_double` is 1, row r is double size. Each cell is 24 dots wide, `font_col` = (dot offset in cell)/2, `font_row` = (line offset in row)/2, and the row occupies 36 lines before row r+1 begins.
- R8: When `cell_code` equals 8'hFE inside the text area, `disp_active` is 0 while the address outputs keep their in-area values.
- R9: Outside the text area (left or right of the columns, above row 0, below row 11), `disp_active` is 0 and all address outputs are 0.
- R10: From reset until the first vsync start, nothing is displayed, even if hsync pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| hsync_high | input | 1 | 1: hsync active-high, 0: active-low |
| vsync_high | input | 1 | 1: vsync active-high, 0: active-low |
| h_start | input | 6 | Horizontal start, in dot clocks beyond the fixed 12 |
| v_start | input | 6 | Vertical start, in lines beyond the fixed 16 |
| row_double | input | 12 | Bit r set: text row r is double size |
| cell_code | input | 8 | Character code of the addressed cell |
| row_addr | output | 4 | Character-memory row address |
| col_addr | output | 5 | Character-memory column address |
| font_row | output | 5 | Font line within the cell |
| font_col | output | 4 | Font dot within the cell |
| disp_active | output | 1 | Current dot belongs to a displayed cell |

## Verification
The bench compares every output on every clock against a model that walks the row heights. It targets the exact first dot and first line of the grid, because a synchroniser off by one stage or a missing fixed offset shifts the whole overlay by one clock or one line. It mixes double and normal rows in one frame. A design that advanced double rows after 18 lines, or that did not halve the font indices, would start the following rows early or return font lines beyond 17. It also covers inverted sync polarity, where a wrong edge choice restarts lines on the trailing edge, and a blank cell, which must go dark while its neighbours and its addresses stay intact.

// File: rtl/osd_raster_pkg.sv
package osd_raster_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Screen and cell geometry
  localparam int ROWS        = 12;
  localparam int COLS        = 24;
  localparam int CELL_W      = 12;
  localparam int CELL_H      = 18;
  localparam int SCALE       = 2;
  // Fixed start offsets and programmable start width
  localparam int H_OFS       = 12;
  localparam int V_OFS       = 16;
  localparam int START_W     = 6;
  localparam int CODE_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam logic [CODE_W-1:0] BLANK_CODE = 8'hFE;

  // Derived widths
  localparam int ROW_W  = $clog2(ROWS + 1);
  localparam int COL_W  = $clog2(COLS);
  localparam int FROW_W = $clog2(CELL_H);
  localparam int FCOL_W = $clog2(CELL_W);
  localparam int LIN_W  = $clog2(SCALE * CELL_H);
  localparam int HCNT_W = $clog2(H_OFS + (1 << START_W) + SCALE * CELL_W * COLS + 1);
  localparam int VCNT_W = $clog2(V_OFS + (1 << START_W) + SCALE * CELL_H * ROWS + 1);

  // Size of a cell dimension, widened for double-size rows
  function automatic int cell_span(input int unit, input logic dbl);
    return dbl ? unit * SCALE : unit;
  endfunction

  // Map a raster offset inside a cell onto a font index
  function automatic int unscale(input int idx, input logic dbl);
    return dbl ? idx / SCALE : idx;
  endfunction
endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge #(
  parameter int STAGES = osd_raster_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic active_high,
  output logic start_evt
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] sq;
  logic              prev_q;
  logic              lvl;

  // Active level after the synchroniser, polarity folded in
  assign lvl       = active_high ? sq[STAGES-1] : ~sq[STAGES-1];
  assign start_evt = lvl & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq     <= '0;
      prev_q <= 1'b1;
    end else begin
      sq     <= {sq[STAGES-2:0], sync_in};
      prev_q <= lvl;
    end
  end
endmodule

// File: rtl/osd_dot_mapper.sv
module osd_dot_mapper
  import osd_raster_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_evt,
  input  logic [START_W-1:0] h_start,
  input  logic               dbl,
  output logic [HCNT_W-1:0]  hcnt,
  output logic               h_on,
  output logic [COL_W-1:0]   col,
  output logic [FCOL_W-1:0]  fcol
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [HCNT_W-1:0] HMAX = '1;

  int base;
  int pos;
  int w;

  // Dot counter: restarts on the hsync start, saturates after the line
  always_ff @(posedge clk) begin
    if (!rst_n)             hcnt <= HMAX;
    else if (hs_evt)        hcnt <= '0;
    else if (hcnt != HMAX)  hcnt <= hcnt + 1'b1;
  end

  always_comb begin
    base = H_OFS + int'(h_start);
    pos  = int'(hcnt) - base;
    w    = cell_span(CELL_W, dbl);
    h_on = (pos >= 0) && (pos < COLS * w);
    col  = h_on ? COL_W'(pos / w) : '0;
    fcol = h_on ? FCOL_W'(unscale(pos % w, dbl)) : '0;
  end
endmodule

// File: rtl/osd_line_tracker.sv
module osd_line_tracker
  import osd_raster_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vs_evt,
  input  logic               hs_evt,
  input  logic [START_W-1:0] v_start,
  input  logic [ROWS-1:0]    dbl_mask,
  output logic               v_on,
  output logic [ROW_W-1:0]   row,
  output logic [LIN_W-1:0]   lin,
  output logic               row_dbl
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [VCNT_W-1:0] VMAX = '1;

  logic [VCNT_W-1:0] vcnt;
  logic [VCNT_W-1:0] vbase;
  logic              row_live;
  logic              last_line;

  assign vbase     = VCNT_W'(V_OFS) + VCNT_W'(v_start);
  assign row_live  = row < ROW_W'(ROWS);
  assign row_dbl   = row_live && dbl_mask[row];
  assign v_on      = (vcnt >= vbase) && row_live;
  assign last_line = int'(lin) == cell_span(CELL_H, row_dbl) - 1;

  // Lines counted by hsync starts; the row walk advances only in the band
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt <= VMAX;
      row  <= ROW_W'(ROWS);
      lin  <= '0;
    end else if (vs_evt) begin
      vcnt <= '0;
      row  <= '0;
      lin  <= '0;
    end else if (hs_evt) begin
      if (vcnt != VMAX) vcnt <= vcnt + 1'b1;
      if (v_on) begin
        if (last_line) begin
          lin <= '0;
          row <= row + 1'b1;
        end else begin
          lin <= lin + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_raster_seq.sv
module osd_raster_seq
  import osd_raster_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               hsync_high,
  input  logic               vsync_high,
  input  logic [START_W-1:0] h_start,
  input  logic [START_W-1:0] v_start,
  input  logic [ROWS-1:0]    row_double,
  input  logic [CODE_W-1:0]  cell_code,
  output logic [ROW_W-1:0]   row_addr,
  output logic [COL_W-1:0]   col_addr,
  output logic [FROW_W-1:0]  font_row,
  output logic [FCOL_W-1:0]  font_col,
  output logic               disp_active
);
  timeunit 1ns;
  timeprecision 1ps;

  // Named internal events, brought out for the checker
  logic              hs_evt;
  logic              vs_evt;
  logic [HCNT_W-1:0] hcnt;
  logic              h_on;
  logic [COL_W-1:0]  col;
  logic [FCOL_W-1:0] fcol;
  logic              v_on;
  logic [ROW_W-1:0]  v_row;
  logic [LIN_W-1:0]  v_lin;
  logic              row_dbl;
  logic              area;
  logic              cell_blank;

  osd_sync_edge #(.STAGES(SYNC_STAGES)) u_hsync (
    .clk(clk), .rst_n(rst_n), .sync_in(hsync_in),
    .active_high(hsync_high), .start_evt(hs_evt)
  );

  osd_sync_edge #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk(clk), .rst_n(rst_n), .sync_in(vsync_in),
    .active_high(vsync_high), .start_evt(vs_evt)
  );

  osd_line_tracker u_lines (
    .clk(clk), .rst_n(rst_n), .vs_evt(vs_evt), .hs_evt(hs_evt),
    .v_start(v_start), .dbl_mask(row_double),
    .v_on(v_on), .row(v_row), .lin(v_lin), .row_dbl(row_dbl)
  );

  osd_dot_mapper u_dots (
    .clk(clk), .rst_n(rst_n), .hs_evt(hs_evt), .h_start(h_start),
    .dbl(row_dbl), .hcnt(hcnt), .h_on(h_on), .col(col), .fcol(fcol)
  );

  assign area        = v_on & h_on;
  assign cell_blank  = cell_code == BLANK_CODE;
  assign disp_active = area & ~cell_blank;
  assign row_addr    = area ? v_row : '0;
  assign col_addr    = area ? col : '0;
  assign font_col    = area ? fcol : '0;
  assign font_row    = area ? FROW_W'(unscale(int'(v_lin), row_dbl)) : '0;
endmodule

// File: rtl/osd_raster_seq_chk.sv
module osd_raster_seq_chk
  import osd_raster_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hs_evt,
  input logic              vs_evt,
  input logic [HCNT_W-1:0] hcnt,
  input logic [ROW_W-1:0]  v_row,
  input logic [LIN_W-1:0]  v_lin,
  input logic [CODE_W-1:0] cell_code,
  input logic [ROW_W-1:0]  row_addr,
  input logic [COL_W-1:0]  col_addr,
  input logic [FROW_W-1:0] font_row,
  input logic [FCOL_W-1:0] font_col,
  input logic              disp_active
);
  timeunit 1ns;
  timeprecision 1ps;

  a_r1_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> (row_addr < ROW_W'(ROWS)) && (col_addr < COL_W'(COLS)));

  a_r6_font_range: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> (font_row < FROW_W'(CELL_H)) && (font_col < FCOL_W'(CELL_W)));

  a_r8_blank_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_code == BLANK_CODE) |-> !disp_active);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_active && cell_code != BLANK_CODE) |->
      (row_addr == '0 && col_addr == '0 && font_row == '0 && font_col == '0));

  a_r3_dot_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hs_evt |=> (hcnt == '0));

  a_r5_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vs_evt |=> (v_row == '0 && v_lin == '0));

  a_r7_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hs_evt |=> (int'(v_lin) < SCALE * CELL_H));
endmodule

bind osd_raster_seq osd_raster_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_evt(hs_evt), .vs_evt(vs_evt), .hcnt(hcnt),
  .v_row(v_row), .v_lin(v_lin), .cell_code(cell_code), .row_addr(row_addr),
  .col_addr(col_addr), .font_row(font_row), .font_col(font_col),
  .disp_active(disp_active)
);

// File: tb/osd_raster_seq_bench.sv
module osd_raster_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hsync, vsync, hs_pol, vs_pol;
  logic [5:0]  h_start, v_start;
  logic [11:0] row_double;
  logic [7:0]  cell_code;
  logic [3:0]  row_addr;
  logic [4:0]  col_addr;
  logic [4:0]  font_row;
  logic [3:0]  font_col;
  logic        disp_active;

  int n_cmp = 0;
  int n_bad = 0;
  int line_no = -1;

  always #2.5 clk = ~clk;

  // Character memory stand-in: two cells hold the blank code (R8)
  assign cell_code = ((row_addr == 4'd1 && col_addr == 5'd3) ||
                      (row_addr == 4'd0 && col_addr == 5'd20)) ? 8'hFE
                     : {row_addr, col_addr[3:0]};

  osd_raster_seq u_osd_raster_seq (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync), .vsync_in(vsync),
    .hsync_high(hs_pol), .vsync_high(vs_pol), .h_start(h_start),
    .v_start(v_start), .row_double(row_double), .cell_code(cell_code),
    .row_addr(row_addr), .col_addr(col_addr), .font_row(font_row),
    .font_col(font_col), .disp_active(disp_active)
  );

  // Expected outputs for line L (hsync starts since vsync) and dot count hc
  task automatic expect_at(input int L, input int hc, output logic act,
                           output int r, output int c, output int fr,
                           output int fc, output logic inarea, output logic dbl);
    int y, x, rr, h, w;
    act = 0; r = 0; c = 0; fr = 0; fc = 0; inarea = 0; dbl = 0;
    if (L < 0) return;
    y = L - (16 + int'(h_start) * 0 + int'(v_start));
    if (y < 0) return;
    rr = 0;
    while (rr < 12) begin
      h = row_double[rr] ? 36 : 18;
      if (y < h) break;
      y -= h;
      rr++;
    end
    if (rr >= 12) return;
    dbl = row_double[rr];
    w = dbl ? 24 : 12;
    x = hc - (12 + int'(h_start));
    if (x < 0 || x >= 24 * w) begin
      dbl = 0;
      return;
    end
    inarea = 1;
    r  = rr;
    c  = x / w;
    fc = dbl ? (x % w) / 2 : x % w;
    fr = dbl ? y / 2 : y;
    act = !((r == 1 && c == 3) || (r == 0 && c == 20));
  endtask

  task automatic check_now(input string tag, input int L, input int hc);
    logic ea, inarea, dbl;
    int er, ec, efr, efc;
    string t;
    expect_at(L, hc, ea, er, ec, efr, efc, inarea, dbl);
    t = tag;
    if (inarea && !ea) t = "R8";
    else if (inarea && dbl) t = "R7";
    else if (!inarea && (tag == "R4" || tag == "R6")) t = "R9";
    n_cmp++;
    if (disp_active !== ea || int'(row_addr) != er || int'(col_addr) != ec ||
        int'(font_row) != efr || int'(font_col) != efc) begin
      n_bad++;
      $display("FAIL %s line=%0d dot=%0d actual act=%b row=%0d col=%0d frow=%0d fcol=%0d expected act=%b row=%0d col=%0d frow=%0d fcol=%0d",
               t, L, hc, disp_active, row_addr, col_addr, font_row, font_col,
               ea, er, ec, efr, efc);
    end
  endtask

  task automatic apply_reset(input logic hp, input logic vp, input int hs,
                             input int vs, input logic [11:0] mask);
    rst_n = 0;
    hs_pol = hp; vs_pol = vp;
    hsync = ~hp; vsync = ~vp;
    h_start = 6'(hs); v_start = 6'(vs);
    row_double = mask;
    repeat (5) @(negedge clk);
    rst_n = 1;
    line_no = -1;
    @(negedge clk);
  endtask

  // One scan line: hsync active for four clocks, check from dot count 0
  task automatic run_line(input int len, input string tag);
    if (line_no >= 0) line_no++;
    hsync = hs_pol;
    for (int m = 1; m <= len; m++) begin
      @(posedge clk);
      @(negedge clk);
      if (m >= 3) check_now(tag, line_no, m - 3);
      if (m == 4) hsync = ~hs_pol;
    end
  endtask

  task automatic frame_start();
    vsync = vs_pol;
    repeat (4) @(negedge clk);
    vsync = ~vs_pol;
    repeat (4) @(negedge clk);
    line_no = 0;
  endtask

  // R10: idle after reset, hsync alone displays nothing
  task automatic t_reset();
    apply_reset(1'b1, 1'b1, 0, 0, 12'h000);
    check_now("R10", -1, 0);
    run_line(120, "R10");
    run_line(120, "R10");
  endtask

  // R3/R4: first line of row 0, exact first dot and column spans
  task automatic t_normal_h();
    apply_reset(1'b1, 1'b1, 5, 0, 12'h000);
    frame_start();
    for (int i = 1; i < 16; i++) run_line(30, "R5");
    run_line(700, "R3");
    run_line(700, "R4");
  endtask

  // R7: a double row, its last line, and the normal row that follows
  task automatic t_double();
    apply_reset(1'b1, 1'b1, 0, 1, 12'h001);
    frame_start();
    for (int i = 1; i < 17; i++) run_line(30, "R5");
    run_line(700, "R7");
    for (int i = 18; i < 52; i++) run_line(30, "R7");
    run_line(700, "R7");
    run_line(700, "R6");
  endtask

  // R2: both syncs active-low, maximum horizontal start
  task automatic t_polarity();
    apply_reset(1'b0, 1'b0, 63, 3, 12'h000);
    frame_start();
    for (int i = 1; i < 19; i++) run_line(30, "R2");
    run_line(700, "R2");
    run_line(700, "R2");
  endtask

  // R1/R5/R6: a whole frame with mixed row sizes
  task automatic t_frame();
    apply_reset(1'b1, 1'b1, 1, 2, 12'h825);
    frame_start();
    for (int L = 1; L <= 308; L++) begin
      if (L <= 18)       run_line(90, "R5");
      else if (L >= 270) run_line(90, "R1");
      else               run_line(90, "R6");
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (R10 run) actual=still running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; hsync = 0; vsync = 0; hs_pol = 1; vs_pol = 1;
    h_start = 0; v_start = 0; row_double = 0;
    @(negedge clk);
    t_reset();
    t_normal_h();
    t_double();
    t_polarity();
    t_frame();
    summary();
    $finish;
  end
endmodule